// File: doc/BRIEF.md
# Call/Return Tracking Execution Monitor

This block observes the stream of retired instructions from a processor core that runs a base 32-bit instruction set with optional 16-bit compressed encodings. Each retirement is a one-cycle strobe carrying the program counter and the instruction word. The block decides whether each instruction transfers control into a function, out of one, both, or neither. The decision uses link-register hints in the destination and source register fields.

The block applies that decision when the *next* instruction retires. At that point the program counter of the new retirement is the address that control reached. A call pushes that address onto a bounded hardware stack and raises a call event. A return pops the most recent entry and raises a return event that carries the popped address. A separate frame-depth counter tracks the call nesting. A small bank of watch addresses, each with its own enable, flags the entries into and exits from functions of interest. A trace-level setting is held for software and does not change the tracking.

All outputs are registered. They reflect a retirement on the clock edge that samples it, and they can be read in the following cycle.

Top module: `callret_monitor`

## Requirements
- R1: When instr[6:0] is 0x67 (indirect jump), links are x1 and x5, rd is bits 11:7 and rs1 is bits 19:15. Only rs1 a link gives a return. Only rd a link gives a call. Both links with different numbers give a call and a return. Both links with the same number give a call only. Neither a link gives no transfer.
- R2: When instr[6:0] is 0x6F (direct jump), the instruction is a call if bits 11:7 name x1 or x5, and otherwise it is no transfer.
- R3: When instr[1:0] is 2 and instr[15:13] is 4 (compressed form), the instruction is a call if bits 11:7 name x1 or x5, and otherwise it is no transfer.
- R4: A retirement whose predecessor was classed as a call pushes its own PC. In the next cycle, call_evt is 1 for one cycle and call_addr equals that PC. call_addr reads 0 whenever call_evt is 0.
- R5: A retirement whose predecessor was classed as a return pops the newest stack entry. In the next cycle, ret_evt is 1 for one cycle and ret_addr equals the popped address. ret_addr reads 0 whenever ret_evt is 0.
- R6: frame_depth rises by one per call and saturates at its maximum. It falls by one per return only when it is non-zero, and otherwise stays at zero.
- R7: A return taken while the stack is empty still raises ret_evt, also raises ret_unknown, and reports the current PC in ret_addr.
- R8: A predecessor classed as both call and return first pops and then pushes in the same cycle. Both events are raised. With a non-zero depth the depth is unchanged. From zero depth it becomes one.
- R9: A push into a full stack (STACK_DEPTH entries) discards the oldest entry, so stack_count stays at STACK_DEPTH, and it sets the sticky overflow flag. ovf_clr clears the flag. A new overflow in the same cycle wins over the clear.
- R10: entry_hit[i] pulses with call_evt when watch slot i is enabled and its address equals the pushed PC. exit_hit[i] pulses with ret_evt when slot i is enabled and its address equals ret_addr. Disabled slots never hit.
- R11: trace_level resets to 0 (call level). A write with lvl_we of 0 (call), 1 (jump) or 2 (all) is stored. A write of 3 is ignored.
- R12: While rst_n is low at a clock edge, the block clears the stack, the depth, the overflow flag, trace_level and all event outputs, and the stored predecessor class becomes no transfer.
- R13: Cycles with ret_valid low raise no event and change neither the stack, the depth nor the stored predecessor class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ret_valid | input | 1 | One instruction retires this cycle |
| ret_pc | input | XLEN | PC of the retiring instruction |
| ret_instr | input | 32 | Retiring instruction word (compressed forms in bits 15:0) |
| lvl_we | input | 1 | Write strobe for the trace level |
| lvl_wdata | input | 2 | Trace level to store |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| watch_addr | input | NUM_WATCH*XLEN | Watch addresses, slot i in bits i*XLEN +: XLEN |
| watch_en | input | NUM_WATCH | Enable for each watch slot |
| call_evt | output | 1 | Function entry seen |
| call_addr | output | XLEN | Entered address |
| ret_evt | output | 1 | Function exit seen |
| ret_addr | output | XLEN | Popped address, or PC when unknown |
| ret_unknown | output | 1 | Exit found the stack empty |
| entry_hit | output | NUM_WATCH | Watch match on entry |
| exit_hit | output | NUM_WATCH | Watch match on exit |
| frame_depth | output | DEPTH_W | Current call nesting |
| stack_count | output | $clog2(STACK_DEPTH+1) | Entries held on the stack |
| overflow | output | 1 | Sticky stack overflow flag |
| trace_level | output | 2 | Stored trace level |

## Verification
On every cycle the assertions check the following. Events only follow a valid retirement. The depth moves by exactly one step in the direction the events imply, with the floor at zero. An unknown return only occurs after an empty stack. Watch hits never appear without their event. The stack count never exceeds its bound. Overflow only rises on a call into a full stack. The classification table, the one-instruction lag, the order of pop before push and the discarding of the oldest entry all need concrete sequences. The bench drives those sequences and compares every output against a queue-based model on each clock.

// File: rtl/callret_pkg.sv
// Shared constants and types for the call/return monitor.
// Assumes the base 32-bit encoding with x1 and x5 acting as link registers.
package callret_pkg;

    typedef enum logic [1:0] {
        TRACE_CALL = 2'd0,
        TRACE_JUMP = 2'd1,
        TRACE_ALL  = 2'd2
    } trace_lvl_e;

    typedef struct packed {
        logic push;
        logic pop;
    } xfer_cls_t;

    localparam logic [6:0] OPC_JUMP_REG = 7'h67;
    localparam logic [6:0] OPC_JUMP_IMM = 7'h6F;
    localparam logic [1:0] CQ_QUAD2     = 2'b10;
    localparam logic [2:0] CQ_FUNC_CALL = 3'b100;
    localparam logic [4:0] LINK_PRI     = 5'd1;
    localparam logic [4:0] LINK_ALT     = 5'd5;

    function automatic logic is_link(input logic [4:0] r);
        return (r == LINK_PRI) || (r == LINK_ALT);
    endfunction

endpackage

// File: rtl/rtr_classify.sv
// Sorts one instruction word into push / pop / both / none.
// Purely combinational; assumes compressed forms sit in bits 15:0.
module rtr_classify
    import callret_pkg::*;
(
    input  logic [31:0] instr,
    output xfer_cls_t   cls
);

    logic [4:0] rd_f;
    logic [4:0] rs1_f;
    logic       rd_lnk;
    logic       rs_lnk;
    logic       unused_bits;

    assign rd_f        = instr[11:7];
    assign rs1_f       = instr[19:15];
    assign rd_lnk      = is_link(rd_f);
    assign rs_lnk      = is_link(rs1_f);
    assign unused_bits = ^{instr[31:20], instr[12]};

    // Decode the link hints per opcode family.
    always_comb begin
        cls = '0;
        if (instr[6:0] == OPC_JUMP_REG) begin
            if (!rd_lnk && rs_lnk) begin
                cls.pop = 1'b1;
            end else if (rd_lnk && !rs_lnk) begin
                cls.push = 1'b1;
            end else if (rd_lnk && rs_lnk) begin
                cls.push = 1'b1;
                cls.pop  = (rd_f != rs1_f);
            end
        end else if (instr[6:0] == OPC_JUMP_IMM) begin
            cls.push = rd_lnk;
        end else if (instr[1:0] == CQ_QUAD2 && instr[15:13] == CQ_FUNC_CALL) begin
            cls.push = rd_lnk;
        end
    end

endmodule

// File: rtl/rtr_stack.sv
// Circular return-address stack. A pop then a push may happen in one cycle.
// A push into a full stack overwrites the oldest entry and reports ovf.
// Assumes DEPTH >= 2; contents are not reset, only pointer and count.
module rtr_stack #(
    parameter  int XLEN  = 32,
    parameter  int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [XLEN-1:0]  din,
    output logic [XLEN-1:0]  dout,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);

    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [XLEN-1:0]  mem [DEPTH];
    logic [PTR_W-1:0] top;
    logic [PTR_W-1:0] ptr_mid;
    logic [PTR_W-1:0] ptr_nxt;
    logic [CNT_W-1:0] cnt_mid;
    logic [CNT_W-1:0] cnt_nxt;
    logic             do_pop;
    logic             full_mid;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
        return (p == '0) ? PTR_LAST : p - 1'b1;
    endfunction

    assign dout = mem[top];

    // Pop first, then push onto the result.
    always_comb begin
        do_pop   = pop && (count != '0);
        cnt_mid  = do_pop ? count - 1'b1 : count;
        ptr_mid  = do_pop ? ptr_dec(top) : top;
        full_mid = (cnt_mid == CNT_FULL);
        ptr_nxt  = push ? ptr_inc(ptr_mid) : ptr_mid;
        cnt_nxt  = (push && !full_mid) ? cnt_mid + 1'b1 : cnt_mid;
        ovf      = push && full_mid;
    end

    // Pointer and occupancy state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top   <= '0;
            count <= '0;
        end else begin
            top   <= ptr_nxt;
            count <= cnt_nxt;
        end
    end

    // Entry storage, written at the new top on a push.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[ptr_nxt] <= din;
        end
    end

endmodule

// File: rtl/rtr_watch.sv
// Compares one address against every enabled watch slot.
// Combinational; slot i occupies bits i*XLEN +: XLEN of watch_addr.
module rtr_watch #(
    parameter int XLEN = 32,
    parameter int NW   = 4
) (
    input  logic [NW*XLEN-1:0] watch_addr,
    input  logic [NW-1:0]      watch_en,
    input  logic               valid,
    input  logic [XLEN-1:0]    addr,
    output logic [NW-1:0]      hit
);

    for (genvar i = 0; i < NW; i++) begin : g_slot
        // One comparator per watch slot.
        always_comb begin
            hit[i] = valid && watch_en[i] && (watch_addr[i*XLEN +: XLEN] == addr);
        end
    end

endmodule

// File: rtl/callret_monitor.sv
// Call/return tracking monitor for a retired-instruction stream.
// The class of the previous valid retirement decides what the current one
// does: its PC is pushed on a call, the stack is popped on a return.
// Assumes at most one retirement per cycle; synchronous active-low reset.
module callret_monitor
    import callret_pkg::*;
#(
    parameter  int XLEN        = 32,
    parameter  int STACK_DEPTH = 16,
    parameter  int NUM_WATCH   = 4,
    parameter  int DEPTH_W     = 8,
    localparam int CNT_W       = $clog2(STACK_DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ret_valid,
    input  logic [XLEN-1:0]           ret_pc,
    input  logic [31:0]               ret_instr,
    input  logic                      lvl_we,
    input  logic [1:0]                lvl_wdata,
    input  logic                      ovf_clr,
    input  logic [NUM_WATCH*XLEN-1:0] watch_addr,
    input  logic [NUM_WATCH-1:0]      watch_en,
    output logic                      call_evt,
    output logic [XLEN-1:0]           call_addr,
    output logic                      ret_evt,
    output logic [XLEN-1:0]           ret_addr,
    output logic                      ret_unknown,
    output logic [NUM_WATCH-1:0]      entry_hit,
    output logic [NUM_WATCH-1:0]      exit_hit,
    output logic [DEPTH_W-1:0]        frame_depth,
    output logic [CNT_W-1:0]          stack_count,
    output logic                      overflow,
    output logic [1:0]                trace_level
);

    localparam logic [DEPTH_W-1:0] DEPTH_MAX = {DEPTH_W{1'b1}};

    xfer_cls_t          cur_cls;
    xfer_cls_t          prev_cls;
    logic               do_push;
    logic               do_pop;
    logic               stk_empty;
    logic [XLEN-1:0]    stk_top;
    logic [XLEN-1:0]    exit_addr;
    logic               stk_ovf;
    logic [NUM_WATCH-1:0] ent_match;
    logic [NUM_WATCH-1:0] ext_match;
    logic [DEPTH_W-1:0] depth_mid;
    logic [DEPTH_W-1:0] depth_nxt;
    trace_lvl_e         lvl_q;

    rtr_classify u_cls (
        .instr (ret_instr),
        .cls   (cur_cls)
    );

    assign do_push   = ret_valid && prev_cls.push;
    assign do_pop    = ret_valid && prev_cls.pop;
    assign stk_empty = (stack_count == '0);
    assign exit_addr = stk_empty ? ret_pc : stk_top;

    rtr_stack #(
        .XLEN  (XLEN),
        .DEPTH (STACK_DEPTH)
    ) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (do_push),
        .pop   (do_pop),
        .din   (ret_pc),
        .dout  (stk_top),
        .count (stack_count),
        .ovf   (stk_ovf)
    );

    rtr_watch #(.XLEN(XLEN), .NW(NUM_WATCH)) u_watch_in (
        .watch_addr (watch_addr),
        .watch_en   (watch_en),
        .valid      (do_push),
        .addr       (ret_pc),
        .hit        (ent_match)
    );

    rtr_watch #(.XLEN(XLEN), .NW(NUM_WATCH)) u_watch_out (
        .watch_addr (watch_addr),
        .watch_en   (watch_en),
        .valid      (do_pop),
        .addr       (exit_addr),
        .hit        (ext_match)
    );

    // Next frame depth: decrement with floor, then saturating increment.
    always_comb begin
        depth_mid = (do_pop && frame_depth != '0) ? frame_depth - 1'b1 : frame_depth;
        depth_nxt = (do_push && depth_mid != DEPTH_MAX) ? depth_mid + 1'b1 : depth_mid;
    end

    // Remember the class of the last valid retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_cls <= '0;
        end else if (ret_valid) begin
            prev_cls <= cur_cls;
        end
    end

    // Registered event outputs and frame depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            call_evt    <= 1'b0;
            call_addr   <= '0;
            ret_evt     <= 1'b0;
            ret_addr    <= '0;
            ret_unknown <= 1'b0;
            entry_hit   <= '0;
            exit_hit    <= '0;
            frame_depth <= '0;
        end else begin
            call_evt    <= do_push;
            call_addr   <= do_push ? ret_pc : '0;
            ret_evt     <= do_pop;
            ret_addr    <= do_pop ? exit_addr : '0;
            ret_unknown <= do_pop && stk_empty;
            entry_hit   <= ent_match;
            exit_hit    <= ext_match;
            frame_depth <= depth_nxt;
        end
    end

    // Sticky overflow flag; a new overflow wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow <= 1'b0;
        end else if (stk_ovf) begin
            overflow <= 1'b1;
        end else if (ovf_clr) begin
            overflow <= 1'b0;
        end
    end

    // Trace-level register; the unused code 3 is refused.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= TRACE_CALL;
        end else if (lvl_we && lvl_wdata != 2'd3) begin
            lvl_q <= trace_lvl_e'(lvl_wdata);
        end
    end

    assign trace_level = lvl_q;

endmodule

// File: rtl/rtr_checker.sv
// Temporal checks on the monitor's outputs, bound into every instance.
module rtr_checker #(
    parameter  int STACK_DEPTH = 16,
    parameter  int NUM_WATCH   = 4,
    parameter  int DEPTH_W     = 8,
    localparam int CNT_W       = $clog2(STACK_DEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ret_valid,
    input logic                 call_evt,
    input logic                 ret_evt,
    input logic                 ret_unknown,
    input logic [NUM_WATCH-1:0] entry_hit,
    input logic [NUM_WATCH-1:0] exit_hit,
    input logic [DEPTH_W-1:0]   frame_depth,
    input logic [CNT_W-1:0]     stack_count,
    input logic                 overflow
);

    localparam logic [DEPTH_W-1:0] DMAX = {DEPTH_W{1'b1}};

    assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ret_valid) |-> (!call_evt && !ret_evt));

    assert_ret_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_evt && !call_evt) |->
        frame_depth == (($past(frame_depth) == '0) ? '0 : $past(frame_depth) - 1'b1));

    assert_call_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (call_evt && !ret_evt) |->
        frame_depth == (($past(frame_depth) == DMAX) ? DMAX : $past(frame_depth) + 1'b1));

    assert_both_depth_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (call_evt && ret_evt && $past(frame_depth) != '0) |->
        frame_depth == $past(frame_depth));

    assert_unknown_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ret_unknown |-> (ret_evt && $past(stack_count) == '0));

    assert_entry_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_hit != '0) |-> call_evt);

    assert_exit_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_hit != '0) |-> ret_evt);

    assert_no_overfill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stack_count <= CNT_W'(STACK_DEPTH));

    assert_ovf_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> (call_evt && stack_count == CNT_W'(STACK_DEPTH)));

endmodule

bind callret_monitor rtr_checker #(
    .STACK_DEPTH (STACK_DEPTH),
    .NUM_WATCH   (NUM_WATCH),
    .DEPTH_W     (DEPTH_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ret_valid   (ret_valid),
    .call_evt    (call_evt),
    .ret_evt     (ret_evt),
    .ret_unknown (ret_unknown),
    .entry_hit   (entry_hit),
    .exit_hit    (exit_hit),
    .frame_depth (frame_depth),
    .stack_count (stack_count),
    .overflow    (overflow)
);

// File: tb/sim_callret_monitor.sv
module sim_callret_monitor;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ret_valid;
    logic [31:0] ret_pc;
    logic [31:0] ret_instr;
    logic        lvl_we;
    logic [1:0]  lvl_wdata;
    logic        ovf_clr;
    logic [127:0] watch_addr;
    logic [3:0]  watch_en;
    logic        call_evt, ret_evt, ret_unknown, overflow;
    logic [31:0] call_addr, ret_addr;
    logic [3:0]  entry_hit, exit_hit;
    logic [7:0]  frame_depth;
    logic [4:0]  stack_count;
    logic [1:0]  trace_level;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference model state
    int unsigned stk[$];
    int          m_depth;
    bit          m_push, m_pop, m_ovf;
    logic [1:0]  m_lvl;
    bit          e_call, e_ret, e_unk;
    int unsigned e_caddr, e_raddr;
    logic [3:0]  e_ehit, e_xhit;

    always #10 clk = ~clk;

    callret_monitor u0 (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_pc(ret_pc),
        .ret_instr(ret_instr), .lvl_we(lvl_we), .lvl_wdata(lvl_wdata),
        .ovf_clr(ovf_clr), .watch_addr(watch_addr), .watch_en(watch_en),
        .call_evt(call_evt), .call_addr(call_addr), .ret_evt(ret_evt),
        .ret_addr(ret_addr), .ret_unknown(ret_unknown), .entry_hit(entry_hit),
        .exit_hit(exit_hit), .frame_depth(frame_depth), .stack_count(stack_count),
        .overflow(overflow), .trace_level(trace_level)
    );

    // Watch slots: 0 and 3 on 0x1000, 1 on 0x2000, 2 on 0x3000 but disabled
    assign watch_addr = {32'h1000, 32'h3000, 32'h2000, 32'h1000};
    assign watch_en   = 4'b1011;

    function automatic logic [3:0] hits(input int unsigned a);
        logic [31:0] s [4] = '{32'h1000, 32'h2000, 32'h3000, 32'h1000};
        logic [3:0] h = '0;
        for (int i = 0; i < 4; i++) h[i] = watch_en[i] && (s[i] == a);
        return h;
    endfunction

    function automatic bit lnk(input int r);
        return r == 1 || r == 5;
    endfunction

    // Behavioural classification from the requirement text (R1, R2, R3)
    function automatic void classify(input logic [31:0] w, output bit pu, output bit po);
        int rd = int'(w[11:7]);
        int rs = int'(w[19:15]);
        pu = 0; po = 0;
        if (w[6:0] == 7'h67) begin
            if (lnk(rs) && !lnk(rd)) po = 1;
            if (lnk(rd)) pu = 1;
            if (lnk(rd) && lnk(rs) && rd != rs) po = 1;
        end else if (w[6:0] == 7'h6F) begin
            pu = lnk(rd);
        end else if (w[1:0] == 2 && w[15:13] == 4) begin
            pu = lnk(rd);
        end
    endfunction

    task automatic chk(input string tag, input string name, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, name, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        chk({tag, "/R4"},  "call_evt",    call_evt,    e_call);
        chk({tag, "/R4"},  "call_addr",   call_addr,   e_caddr);
        chk({tag, "/R5"},  "ret_evt",     ret_evt,     e_ret);
        chk({tag, "/R5"},  "ret_addr",    ret_addr,    e_raddr);
        chk({tag, "/R7"},  "ret_unknown", ret_unknown, e_unk);
        chk({tag, "/R10"}, "entry_hit",   entry_hit,   e_ehit);
        chk({tag, "/R10"}, "exit_hit",    exit_hit,    e_xhit);
        chk({tag, "/R6"},  "frame_depth", frame_depth, m_depth);
        chk({tag, "/R9"},  "stack_count", stack_count, stk.size());
        chk({tag, "/R9"},  "overflow",    overflow,    m_ovf);
        chk({tag, "/R11"}, "trace_level", trace_level, m_lvl);
    endtask

    // Drive one cycle, advance the model, compare after the edge
    task automatic step(input string tag, input bit v, input int unsigned pc,
                        input logic [31:0] ins, input bit we = 0,
                        input logic [1:0] ld = 0, input bit clr = 0);
        bit ovf_set = 0;
        ret_valid = v; ret_pc = pc; ret_instr = ins;
        lvl_we = we; lvl_wdata = ld; ovf_clr = clr;
        e_call = 0; e_ret = 0; e_unk = 0; e_caddr = 0; e_raddr = 0;
        e_ehit = 0; e_xhit = 0;
        if (v) begin
            if (m_pop) begin
                e_ret = 1;
                if (stk.size() > 0) e_raddr = stk.pop_back();
                else begin e_unk = 1; e_raddr = pc; end
                if (m_depth > 0) m_depth--;
                e_xhit = hits(e_raddr);
            end
            if (m_push) begin
                e_call = 1; e_caddr = pc;
                if (stk.size() == 16) begin void'(stk.pop_front()); ovf_set = 1; end
                stk.push_back(pc);
                if (m_depth < 255) m_depth++;
                e_ehit = hits(pc);
            end
            classify(ins, m_push, m_pop);
        end
        if (ovf_set) m_ovf = 1;
        else if (clr) m_ovf = 0;
        if (we && ld != 3) m_lvl = ld;
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic do_reset();
        rst_n = 0; ret_valid = 0; ret_pc = 0; ret_instr = 0;
        lvl_we = 0; lvl_wdata = 0; ovf_clr = 0;
        @(posedge clk);
        @(negedge clk);
        stk.delete(); m_depth = 0; m_push = 0; m_pop = 0; m_ovf = 0; m_lvl = 0;
        e_call = 0; e_ret = 0; e_unk = 0; e_caddr = 0; e_raddr = 0;
        e_ehit = 0; e_xhit = 0;
        compare_all("R12");
        rst_n = 1;
    endtask

    localparam logic [31:0] NOP      = 32'h00000013;
    localparam logic [31:0] JAL_RA   = 32'h000000EF;
    localparam logic [31:0] JAL_T0   = 32'h000002EF;
    localparam logic [31:0] JAL_ZERO = 32'h0000006F;
    localparam logic [31:0] JR_RA    = 32'h00008067;
    localparam logic [31:0] JR_T0    = 32'h00028067;
    localparam logic [31:0] JALR_CALL= 32'h000300E7;
    localparam logic [31:0] JALR_BTH = 32'h000280E7;
    localparam logic [31:0] JALR_SAM = 32'h000080E7;
    localparam logic [31:0] JALR_NON = 32'h00018167;
    localparam logic [31:0] C_CALL   = 32'h00008082;
    localparam logic [31:0] C_NONE   = 32'h00008102;

    initial begin
        do_reset();
        // R13: idle cycles between a call and its target
        step("R2",  1, 32'h100, JAL_RA);
        step("R13", 0, 32'hDEAD, JR_RA);
        step("R13", 0, 32'hBEEF, NOP);
        step("R4",  1, 32'h1000, JR_RA);   // call into 0x1000, hits 0 and 3
        step("R5",  1, 32'h104, NOP);      // return pops 0x1000
        // R2: jal with x5 and with x0
        step("R2",  1, 32'h108, JAL_T0);
        step("R2",  1, 32'h2000, JAL_ZERO);
        step("R2",  1, 32'h2004, C_CALL);  // no transfer from jal x0
        // R3: compressed call and non-link form
        step("R3",  1, 32'h3000, C_NONE);  // slot 2 disabled
        step("R3",  1, 32'h3002, JALR_CALL);
        // R1: jalr forms
        step("R1",  1, 32'h4000, JALR_SAM);
        step("R1",  1, 32'h5000, JALR_NON);
        step("R1",  1, 32'h5004, JALR_BTH);
        // R8: pop then push with a non-empty stack
        step("R8",  1, 32'h6000, JR_T0);
        for (int i = 0; i < 6; i++) step("R7", 1, 32'h7000 + 4 * i, JR_T0);
        step("R7",  1, 32'h7100, JALR_BTH);
        // R8 with an empty stack: unknown return plus a call
        step("R8",  1, 32'h7200, NOP);
        step("R6",  1, 32'h7204, JR_RA);
        step("R6",  1, 32'h7208, NOP);
        // R9: fill the stack past its bound
        for (int i = 0; i < 19; i++) step("R9", 1, 32'h8000 + 16 * i, JAL_RA);
        step("R9",  1, 32'h8400, JAL_RA, 0, 0, 1); // overflow wins over clear
        step("R9",  0, 0, NOP, 0, 0, 1);
        step("R9",  1, 32'h8500, JR_RA);
        for (int i = 0; i < 19; i++) step("R9", 1, 32'h8600 + 4 * i, JR_RA);
        step("R9",  1, 32'h8700, NOP);
        // R11: trace level writes
        step("R11", 0, 0, NOP, 1, 2);
        step("R11", 0, 0, NOP, 1, 3);
        step("R11", 0, 0, NOP, 1, 1);
        step("R11", 0, 0, NOP, 0, 0);
        step("R11", 0, 0, NOP, 1, 0);
        step("R11", 0, 0, NOP, 1, 2);
        // R12: reset drops a pending call class and the stack
        step("R12", 1, 32'h9000, JAL_RA);
        step("R12", 1, 32'h9100, JAL_RA);
        do_reset();
        step("R12", 1, 32'h9200, NOP);
        step("R12", 1, 32'h9204, NOP);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule